// File: doc/BRIEF.md
# Receive FIFO with Per-Character and Block Error Status

This block is a three-deep first-in first-out buffer that sits between a serial receiver's character assembly logic and a host read port. The receiver presents each finished character as a one-cycle write strobe. The strobe carries the data byte and three error flags: parity error, framing error and break. The flags are stored in the same entry as the data. Because of this, each entry keeps its own flags as it moves toward the head of the queue.

The host sees the head entry on the read data output. A one-cycle read strobe pops the head entry. The block reports whether data is available, whether the buffer is full, and whether a character was lost to overrun. The error flags are reported in one of two ways, selected by a mode input:

- **Character view:** the flags of the current head entry.
- **Block view:** an accumulated OR of the flags of every entry that has reached the head since the last error-clear strobe.

The error-clear strobe also clears the overrun flag.

Top module: `rxq_status`

## Requirements
- R1: After reset, `rdy`, `full` and `ovr` are 0, all status outputs are 0, and `rd_data` is 0.
- R2: Characters are returned in arrival order, with up to 3 held at once. While at least one entry is held, `rd_data` shows the data of the oldest entry. When the buffer is empty, `rd_data` is 0.
- R3: `rdy` is 1 exactly when 1 to 3 entries are held. `full` is 1 exactly when 3 entries are held.
- R4: A `rd_en` pulse removes the head entry. A `rd_en` pulse on an empty buffer changes nothing.
- R5: With `block_mode`=0, `st_perr`, `st_ferr` and `st_brk` equal the flags stored with the head entry. They are 0 when the buffer is empty.
- R6: With `block_mode`=1, each status output is the OR of that flag over all entries that have become the head since the last `err_clr`. An entry becomes the head in two cases: it is written into an empty buffer, or a pop exposes it.
- R7: A write while full and without a read sets `ovr` and discards the new character. The held entries are unchanged. `ovr` stays 1 until `err_clr`.
- R8: A write and a read in the same cycle on a full buffer are both accepted. `ovr` does not change, the buffer stays full, and the new character becomes the tail.
- R9: `err_clr` clears `ovr` and the block accumulator in the next cycle. If an overrun happens in the clearing cycle, `ovr` is set anyway. If an entry becomes the head in the clearing cycle, its flags are kept in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character-complete strobe from the receiver |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error flag of the character |
| wr_ferr | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | Host read (pop) strobe |
| block_mode | input | 1 | 0 selects the character view, 1 selects the block view |
| err_clr | input | 1 | Clears overrun and the block accumulator |
| rd_data | output | 8 | Data of the head entry |
| rdy | output | 1 | At least one character is held |
| full | output | 1 | All three positions are held |
| ovr | output | 1 | Sticky overrun flag |
| st_perr | output | 1 | Reported parity error |
| st_ferr | output | 1 | Reported framing error |
| st_brk | output | 1 | Reported break |

## Verification
The risky collisions are a receiver write and a host read landing in the same cycle.

- **Full buffer:** the write must be taken without an overrun.
- **One held entry:** the incoming character must become the new head, and in block mode its flags must be accumulated.

The bench drives both strobes in the same cycle at fill levels 0, 1 and 3. It also places `err_clr` in the same cycle as an overrun and as a change of head. It judges each case against a queue model built from the requirements, comparing data, fill flags, overrun and status after every edge.

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          wr_brk,
  input  logic          rd_en,
  input  logic          block_mode,
  input  logic          err_clr,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          full,
  output logic          ovr,
  output logic          st_perr,
  output logic          st_ferr,
  output logic          st_brk
);
  localparam int EW = DW + 3;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [2:0]    acc;
  logic          ovr_q;

  wire          pop    = rd_en && (cnt != '0);
  wire          is_ful = (cnt == CW'(DEPTH));
  wire          ovf    = wr_en && is_ful && !pop;
  wire          push   = wr_en && !ovf;
  wire [CW-1:0] wpos   = cnt - CW'(pop);
  wire [EW-1:0] win    = {wr_brk, wr_ferr, wr_perr, wr_data};
  wire          expose = pop && (cnt > CW'(1));
  wire          newtop = (push && wpos == '0) || expose;
  wire [2:0]    ntflg  = expose ? mem[1][EW-1:DW] : win[EW-1:DW];
  wire [2:0]    topflg = rdy ? mem[0][EW-1:DW] : 3'b000;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && wpos == CW'(i))
        mem[i] <= win;
      else if (pop && i < DEPTH - 1)
        mem[i] <= mem[(i + 1) % DEPTH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      acc   <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt   <= cnt + CW'(push) - CW'(pop);
      acc   <= (err_clr ? 3'b000 : acc) | (newtop ? ntflg : 3'b000);
      ovr_q <= (ovr_q && !err_clr) || ovf;
    end
  end

  assign rdy     = (cnt != '0);
  assign full    = is_ful;
  assign ovr     = ovr_q;
  assign rd_data = rdy ? mem[0][DW-1:0] : '0;
  assign {st_brk, st_ferr, st_perr} = block_mode ? acc : topflg;
endmodule

module rxq_status_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic block_mode,
  input logic err_clr,
  input logic rdy,
  input logic full,
  input logic ovr,
  input logic st_perr,
  input logic st_ferr,
  input logic st_brk
);
  // R3
  full_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> rdy);
  // R7
  ovr_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> ovr);
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !err_clr) |=> ovr);
  // R8
  full_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && rd_en) |=> (full && $stable(ovr)));
  // R4
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && rd_en && !wr_en) |=> !rdy);
  // R9
  clr_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(full && wr_en && !rd_en)) |=> !ovr);
  // R5
  always @(negedge clk)
    if (rst_n && !block_mode && !rdy)
      empty_status_chk: assert ({st_perr, st_ferr, st_brk} == 3'b000);
endmodule

bind rxq_status rxq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .block_mode(block_mode), .err_clr(err_clr), .rdy(rdy), .full(full),
  .ovr(ovr), .st_perr(st_perr), .st_ferr(st_ferr), .st_brk(st_brk)
);

// File: tb/sim_rxq_status.sv
module sim_rxq_status;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, block_mode = 0, err_clr = 0;
  logic [7:0] wr_data = 0;
  logic       wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic [7:0] rd_data;
  logic       rdy, full, ovr, st_perr, st_ferr, st_brk;

  int checks = 0, fails = 0;
  logic [10:0] q[$];
  logic [2:0]  m_acc = 0;
  logic        m_ovr = 0;

  always #4 clk = ~clk;

  rxq_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en),
    .block_mode(block_mode), .err_clr(err_clr), .rd_data(rd_data),
    .rdy(rdy), .full(full), .ovr(ovr), .st_perr(st_perr),
    .st_ferr(st_ferr), .st_brk(st_brk)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [2:0] exp_st;
    check("R3 rdy", rdy, q.size() > 0);
    check("R3 full", full, q.size() == 3);
    check("R2 rd_data", rd_data, q.size() > 0 ? q[0][7:0] : 0);
    check("R7 ovr", ovr, m_ovr);
    exp_st = block_mode ? m_acc : (q.size() > 0 ? q[0][10:8] : 3'b000);
    check(block_mode ? "R6 status" : "R5 status", {st_brk, st_ferr, st_perr}, exp_st);
  endtask

  // flags = {brk, ferr, perr}
  task automatic step(bit w, logic [7:0] d, logic [2:0] f, bit r, bit clr);
    bit pop, ovf, nt;
    int n;
    @(negedge clk);
    wr_en = w; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f; rd_en = r; err_clr = clr;
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; err_clr = 0;
    n   = q.size();
    pop = r && n > 0;
    ovf = w && n == 3 && !pop;
    nt  = (w && !ovf && (n == 0 || (n == 1 && pop))) || (pop && n >= 2);
    if (pop) void'(q.pop_front());
    if (w && !ovf) q.push_back({f, d});
    m_acc = (clr ? 3'b000 : m_acc) | (nt ? q[0][10:8] : 3'b000);
    m_ovr = (m_ovr && !clr) || ovf;
    compare_all();
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    check("R1 rdy", rdy, 0);
    check("R1 full", full, 0);
    check("R1 ovr", ovr, 0);
    check("R1 status", {st_brk, st_ferr, st_perr}, 0);
    check("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    block_mode = 0;
    step(1, 8'h11, 3'b001, 0, 0);
    step(1, 8'h22, 3'b010, 0, 0);
    step(1, 8'h33, 3'b100, 0, 0);
    check("R3 full after three", full, 1);
    step(0, 0, 0, 1, 0);
    check("R2 second is head", rd_data, 8'h22);
    check("R5 head ferr", st_ferr, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    check("R4 empty after pops", rdy, 0);
  endtask

  task automatic t_rd_empty();
    step(0, 0, 0, 1, 0);
    check("R4 empty read no effect", rdy, 0);
    step(1, 8'h5A, 3'b000, 1, 0);
    check("R4 write+read on empty keeps data", rd_data, 8'h5A);
    drain();
  endtask

  task automatic t_overrun();
    step(1, 8'hA1, 0, 0, 0);
    step(1, 8'hA2, 0, 0, 0);
    step(1, 8'hA3, 0, 0, 0);
    step(1, 8'hEE, 3'b111, 0, 0);
    check("R7 ovr set", ovr, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    check("R7 tail not overwritten", rd_data, 8'hA3);
    step(0, 0, 0, 1, 0);
    check("R7 ovr sticky", ovr, 1);
    step(0, 0, 0, 0, 1);
    check("R9 ovr cleared", ovr, 0);
  endtask

  task automatic t_full_wr_rd();
    step(1, 8'hB1, 0, 0, 0);
    step(1, 8'hB2, 0, 0, 0);
    step(1, 8'hB3, 0, 0, 0);
    step(1, 8'hB4, 3'b010, 1, 0);
    check("R8 no ovr", ovr, 0);
    check("R8 still full", full, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    check("R8 new tail", rd_data, 8'hB4);
    drain();
  endtask

  task automatic t_block();
    block_mode = 1;
    step(0, 0, 0, 0, 1);
    step(1, 8'hC1, 3'b001, 0, 0);
    check("R6 first write into empty", st_perr, 1);
    step(1, 8'hC2, 3'b100, 0, 0);
    check("R6 brk not yet at head", st_brk, 0);
    step(0, 0, 0, 1, 0);
    check("R6 brk accumulated", {st_brk, st_perr}, 2'b11);
    step(1, 8'hC3, 3'b010, 1, 0);
    check("R6 one held wr+rd new head", st_ferr, 1);
    step(0, 0, 0, 0, 1);
    check("R9 acc cleared", {st_brk, st_ferr, st_perr}, 0);
    block_mode = 0;
    #1 compare_all();
    check("R5 char view of head", st_ferr, 1);
    block_mode = 1;
    drain();
  endtask

  task automatic t_clear_collide();
    block_mode = 1;
    step(1, 8'hD1, 3'b000, 0, 0);
    step(1, 8'hD2, 3'b001, 0, 0);
    step(0, 0, 0, 1, 1);
    check("R9 new head flags kept on clear", st_perr, 1);
    step(1, 8'hD3, 0, 0, 0);
    step(1, 8'hD4, 0, 0, 0);
    step(1, 8'hD5, 0, 0, 1);
    check("R9 overrun in clear cycle sets", ovr, 1);
    drain();
    block_mode = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_order();
    t_rd_empty();
    t_overrun();
    t_full_wr_rd();
    t_block();
    t_clear_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule